// File: doc/BRIEF.md
# Phase-Skewed Clock Bank Generator

This block is the digital output stage of a multi-bank zero-delay clock driver. It is clocked by a fast time-unit tick. It builds a nominal clock whose period is a selectable number of ticks, and from that clock it derives four output banks of two outputs each. Each bank has a two-digit three-level select code. The code moves the bank's edges earlier or later in whole time units. For banks 3 and 4, the code can also give a divided or inverted copy of the nominal clock instead of a skew.

A three-level range input sets how many ticks make up one nominal period. A three-level test input bypasses the tick-derived clock: every bank then follows a reference input directly, and the divide and invert choices still apply. The block samples changes to the range and bank selects only at nominal period boundaries, so an output never produces a shortened pulse.

Top module: `clk_skew_bank_gen`

## Requirements
- R1: While rst_n is low every output is 0. The first tick edge with rst_n high starts period 0 and samples the range and bank selects.
- R2: Each three-level input uses two bits per digit: 00 = L, 01 = M, 10 = H. Range L, M and H give nominal periods of 32, 16 and 8 ticks. The nominal clock is high for the first half of each period and low for the second half.
- R3: A bank select has four bits. Bits [3:2] are the first digit and bits [1:0] are the second. The code index is 3*first + second (LL = 0 through HH = 8). Banks 1 and 2 skew by (index - 4) ticks, and a positive value delays the edges.
- R4: Banks 3 and 4 with index 1 to 7 skew by 2*(index - 4) ticks, which gives -6 to +6.
- R5: A negative skew s is produced as a delay of (period + s) ticks within the period. A skewed bank therefore has the same period as the nominal clock.
- R6: Bank 3 with index 0 (LL) divides by 2: high for the whole of period 0, low for period 1, and so on. Bank 3 with index 8 (HH) divides by 4: high for two periods, then low for two.
- R7: Bank 4 with index 0 divides by 2 in the same way as bank 3. Bank 4 with index 8 gives the inverted nominal clock.
- R8: The two-bit value 11 in any three-level field is read as M.
- R9: A change to the range or bank selects takes effect only at the first tick of the next nominal period.
- R10: A test select of M or H routes ref_in to every skew-mode output, and the skew is ignored. Test select L gives normal operation.
- R11: In bypass, a divide-by-2 output toggles at the first tick edge after each rising edge of ref_in, starting low after reset. Bank 3 HH toggles on every second such rising edge. Bank 4 HH gives the inverse of ref_in.
- R12: The two outputs of each bank are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | time-unit tick clock |
| rst_n | input | 1 | active-low synchronous reset |
| range_sel | input | 2 | three-level period range select |
| test_sel | input | 2 | three-level bypass select |
| ref_in | input | 1 | reference clock used in bypass |
| b1_sel | input | 4 | bank 1 skew code |
| b2_sel | input | 4 | bank 2 skew code |
| b3_sel | input | 4 | bank 3 skew/divide code |
| b4_sel | input | 4 | bank 4 skew/divide/invert code |
| q1 | output | 2 | bank 1 outputs |
| q2 | output | 2 | bank 2 outputs |
| q3 | output | 2 | bank 3 outputs |
| q4 | output | 2 | bank 4 outputs |

## Verification
The bench goes after the following corner cases:
- Negative skews at the shortest period (8 ticks), where a skew of -6 wraps to a delay of 2. A design that subtracted without wrapping would give a wrong delay or an output stuck at one level.
- A range and skew change in the middle of a period. A design that applied it at once would cut the period short, and the per-tick comparison would show it.
- The illegal code 11, which a careless decoder would read as H or as an index above 8.
- Divide and invert in bypass. A design that kept the tick-derived dividers there, or that applied skew to the reference, would differ from the edge-counted reference model.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

  typedef enum logic [1:0] {MD_SKEW, MD_DIV2, MD_DIV4, MD_INV} bmode_e;

  // three-level digit: 00 L, 01 M, 10 H, 11 read as M
  function automatic logic [1:0] trit_val(input logic [1:0] c);
    return (c == 2'b11) ? 2'b01 : c;
  endfunction

  function automatic int unsigned mf_pick(input logic [1:0] c, input int unsigned lo,
                                          input int unsigned mid, input int unsigned hi);
    case (trit_val(c))
      2'b00:   return lo;
      2'b01:   return mid;
      default: return hi;
    endcase
  endfunction

  function automatic logic [3:0] code_idx(input logic [3:0] sel);
    return 4'(3 * int'(trit_val(sel[3:2])) + int'(trit_val(sel[1:0])));
  endfunction

  function automatic bmode_e mode_of(input int bank, input logic [3:0] idx);
    if (bank < 3)   return MD_SKEW;
    if (idx == 4'd0) return MD_DIV2;
    if (idx == 4'd8) return (bank == 3) ? MD_DIV4 : MD_INV;
    return MD_SKEW;
  endfunction

  function automatic int skew_of(input int bank, input logic [3:0] idx);
    return ((bank < 3) ? 1 : 2) * (int'(idx) - 4);
  endfunction

  function automatic int delay_of(input int skew, input int mf);
    return (skew < 0) ? mf + skew : skew;
  endfunction

endpackage

// File: rtl/ckb_phase.sv
module ckb_phase #(
  parameter int unsigned MF_LO  = 32,
  parameter int unsigned MF_MID = 16,
  parameter int unsigned MF_HI  = 8,
  parameter int PH_W = $clog2(MF_LO),
  parameter int MF_W = PH_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      range_sel,
  output logic [PH_W-1:0] ph,
  output logic [MF_W-1:0] mf_cur,
  output logic [1:0]      per,
  output logic            wrap,
  output logic            loaded
);
  import clkbank_pkg::*;

  assign wrap = !loaded || ({1'b0, ph} == mf_cur - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      ph     <= '0;
      mf_cur <= MF_W'(MF_LO);
      per    <= '0;
    end else if (wrap) begin
      loaded <= 1'b1;
      ph     <= '0;
      mf_cur <= MF_W'(mf_pick(range_sel, MF_LO, MF_MID, MF_HI));
      if (loaded) per <= per + 2'd1;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  // R2: the phase never leaves the current period
  p_ph_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> ({1'b0, ph} < mf_cur));
  // R9: the period length moves only right after a boundary
  p_mf_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mf_cur) |-> $past(wrap));

endmodule

// File: rtl/ckb_refdiv.sv
module ckb_refdiv #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  output logic [CNT_W-1:0] rcnt
);
  logic ref_q;
  logic ref_rise;

  assign ref_rise = ref_in && !ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      rcnt  <= '0;
    end else begin
      ref_q <= ref_in;
      if (ref_rise) rcnt <= rcnt + 1'b1;
    end
  end

  // R11: the edge counter advances by one per reference rise and never jumps
  p_rcnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rcnt) |-> (rcnt == $past(rcnt) + 1'b1));

endmodule

// File: rtl/ckb_bank.sv
module ckb_bank #(
  parameter int BANK = 1,
  parameter int PH_W = 5,
  parameter int MF_W = PH_W + 1,
  parameter int OUT_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             loaded,
  input  logic             bypass,
  input  logic             ref_in,
  input  logic [PH_W-1:0]  ph,
  input  logic [MF_W-1:0]  mf_cur,
  input  logic [1:0]       per,
  input  logic [1:0]       rcnt,
  input  logic [3:0]       sel,
  output logic [OUT_N-1:0] q
);
  import clkbank_pkg::*;

  logic [3:0]      sel_q;
  logic [3:0]      idx;
  bmode_e          mode;
  logic [MF_W-1:0] dly, ph_w, diff, half;
  logic            nom_bit, bit_out;
  int              dly_i;

  always_ff @(posedge clk) begin
    if (!rst_n)    sel_q <= 4'b0101;
    else if (wrap) sel_q <= sel;
  end

  always_comb begin
    idx   = code_idx(sel_q);
    mode  = mode_of(BANK, idx);
    dly_i = delay_of(skew_of(BANK, idx), int'(mf_cur));
    dly   = MF_W'(dly_i);
    ph_w  = {1'b0, ph};
    half  = mf_cur >> 1;
    diff  = (ph_w >= dly) ? (ph_w - dly) : (ph_w + mf_cur - dly);
    nom_bit = diff < half;
    if (bypass) begin
      case (mode)
        MD_DIV2: bit_out = rcnt[0];
        MD_DIV4: bit_out = rcnt[1];
        MD_INV:  bit_out = !ref_in;
        default: bit_out = ref_in;
      endcase
    end else begin
      case (mode)
        MD_DIV2: bit_out = !per[0];
        MD_DIV4: bit_out = !per[1];
        MD_INV:  bit_out = !(ph_w < half);
        default: bit_out = nom_bit;
      endcase
    end
  end

  assign q = loaded ? {OUT_N{bit_out}} : '0;

  // R9: the latched code changes only at a boundary
  p_sel_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(wrap));
  // R3: a zero-skew code starts the period high
  p_zero_skew_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !bypass && code_idx(sel) == 4'd4) |=> (bypass || q == {OUT_N{1'b1}}));

  generate
    if (BANK >= 3) begin : g_div_chk
      // R6: divide-by-2 flips level across every boundary
      p_div2_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && wrap && !bypass && mode == MD_DIV2 && code_idx(sel) == 4'd0)
        |=> (bypass || q[0] != $past(q[0])));
    end
  endgenerate

endmodule

// File: rtl/clk_skew_bank_gen.sv
module clk_skew_bank_gen #(
  parameter int unsigned MF_LO  = 32,
  parameter int unsigned MF_MID = 16,
  parameter int unsigned MF_HI  = 8,
  parameter int N_BANK = 4,
  parameter int OUT_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       range_sel,
  input  logic [1:0]       test_sel,
  input  logic             ref_in,
  input  logic [3:0]       b1_sel,
  input  logic [3:0]       b2_sel,
  input  logic [3:0]       b3_sel,
  input  logic [3:0]       b4_sel,
  output logic [OUT_N-1:0] q1,
  output logic [OUT_N-1:0] q2,
  output logic [OUT_N-1:0] q3,
  output logic [OUT_N-1:0] q4
);
  import clkbank_pkg::*;

  localparam int PH_W = $clog2(MF_LO);
  localparam int MF_W = PH_W + 1;

  logic [PH_W-1:0]  ph;
  logic [MF_W-1:0]  mf_cur;
  logic [1:0]       per, rcnt;
  logic             wrap, loaded, bypass;
  logic [3:0]       sel_arr [N_BANK];
  logic [OUT_N-1:0] q_arr   [N_BANK];

  assign bypass = (trit_val(test_sel) != 2'b00);
  assign sel_arr[0] = b1_sel;
  assign sel_arr[1] = b2_sel;
  assign sel_arr[2] = b3_sel;
  assign sel_arr[3] = b4_sel;

  ckb_phase #(.MF_LO(MF_LO), .MF_MID(MF_MID), .MF_HI(MF_HI), .PH_W(PH_W), .MF_W(MF_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .ph(ph), .mf_cur(mf_cur),
    .per(per), .wrap(wrap), .loaded(loaded));

  ckb_refdiv #(.CNT_W(2)) u_refdiv (.clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rcnt(rcnt));

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    ckb_bank #(.BANK(g + 1), .PH_W(PH_W), .MF_W(MF_W), .OUT_N(OUT_N)) u_bank (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .loaded(loaded), .bypass(bypass),
      .ref_in(ref_in), .ph(ph), .mf_cur(mf_cur), .per(per), .rcnt(rcnt),
      .sel(sel_arr[g]), .q(q_arr[g]));
  end

  assign q1 = q_arr[0];
  assign q2 = q_arr[1];
  assign q3 = q_arr[2];
  assign q4 = q_arr[3];

  // R10: in bypass bank 1 follows the reference whatever its code
  p_bypass_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && loaded && code_idx(b1_sel) == code_idx(b1_sel)) |-> (q1 == {OUT_N{ref_in}}));
  // R1: nothing toggles before the first period starts
  p_quiet_before_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (q1 == '0 && q2 == '0 && q3 == '0 && q4 == '0));

endmodule

// File: tb/clk_skew_bank_gen_tb.sv
module clk_skew_bank_gen_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, ref_in;
  logic [1:0] range_sel, test_sel;
  logic [3:0] b1_sel, b2_sel, b3_sel, b4_sel;
  logic [1:0] q1, q2, q3, q4;

  clk_skew_bank_gen u_dut (
    .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .test_sel(test_sel), .ref_in(ref_in),
    .b1_sel(b1_sel), .b2_sel(b2_sel), .b3_sel(b3_sel), .b4_sel(b4_sel),
    .q1(q1), .q2(q2), .q3(q3), .q4(q4));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit         m_loaded, m_rprev;
  int         m_ph, m_mf, m_per, m_rcnt;
  logic [3:0] m_sel [1:4];

  function automatic int tv(input logic [1:0] c);
    return (c == 2'b11) ? 1 : int'(c);
  endfunction

  function automatic int mf_from(input logic [1:0] c);
    int t = tv(c);
    return (t == 0) ? 32 : (t == 1) ? 16 : 8;
  endfunction

  task automatic latch_cfg();
    m_mf = mf_from(range_sel);
    m_sel[1] = b1_sel; m_sel[2] = b2_sel; m_sel[3] = b3_sel; m_sel[4] = b4_sel;
  endtask

  task automatic model_edge();
    if (!m_loaded) begin
      m_loaded = 1; m_ph = 0; m_per = 0; latch_cfg();
    end else if (m_ph == m_mf - 1) begin
      m_ph = 0; m_per++; latch_cfg();
    end else m_ph++;
    if (ref_in && !m_rprev) m_rcnt++;
    m_rprev = ref_in;
  endtask

  function automatic bit exp_bank(input int b);
    int v, s, d, df;
    bit byp;
    if (!m_loaded) return 1'b0;
    v   = 3 * tv(m_sel[b][3:2]) + tv(m_sel[b][1:0]);
    byp = tv(test_sel) != 0;
    if (b >= 3 && v == 0) return byp ? (m_rcnt % 2 == 1) : (m_per % 2 == 0);
    if (b == 3 && v == 8) return byp ? ((m_rcnt / 2) % 2 == 1) : ((m_per / 2) % 2 == 0);
    if (b == 4 && v == 8) return byp ? !ref_in : !(m_ph < m_mf / 2);
    if (byp) return ref_in;
    s  = (b <= 2) ? v - 4 : 2 * (v - 4);
    d  = (s < 0) ? m_mf + s : s;
    df = (m_ph - d + m_mf) % m_mf;
    return df < m_mf / 2;
  endfunction

  task automatic check_outs(input string tag);
    logic [1:0] got [1:4];
    got[1] = q1; got[2] = q2; got[3] = q3; got[4] = q4;
    for (int b = 1; b <= 4; b++) begin
      bit e = exp_bank(b);
      checks++;
      if (got[b][0] !== e) begin
        fails++;
        $display("FAIL %s bank%0d ph=%0d per=%0d got=%b exp=%b", tag, b, m_ph, m_per, got[b][0], e);
      end
      checks++;
      if (got[b][1] !== got[b][0]) begin // R12
        fails++;
        $display("FAIL R12 bank%0d pair got=%b exp=%b", b, got[b][1], {2{got[b][0]}});
      end
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #1;
    check_outs(tag);
  endtask

  task automatic do_reset(input logic [1:0] rg, input logic [1:0] ts, input logic [3:0] s1,
                          input logic [3:0] s2, input logic [3:0] s3, input logic [3:0] s4);
    @(negedge clk);
    rst_n = 0; ref_in = 0;
    range_sel = rg; test_sel = ts; b1_sel = s1; b2_sel = s2; b3_sel = s3; b4_sel = s4;
    m_loaded = 0; m_rprev = 0; m_rcnt = 0;
    repeat (3) @(negedge clk);
    #1;
    check_outs("R1");
    rst_n = 1;
  endtask

  // R1, R2, R3, R4: range L, mixed skews
  task automatic t_range_low();
    do_reset(2'b00, 2'b00, 4'b0000, 4'b1010, 4'b0001, 4'b1001);
    repeat (96) tick("R2,R3,R4");
  endtask

  // R2, R5: range M with negative skews
  task automatic t_range_mid();
    do_reset(2'b01, 2'b00, 4'b0100, 4'b0110, 4'b0010, 4'b0100);
    repeat (48) tick("R2,R5");
  endtask

  // R5: range H, -6 wraps to a delay of 2
  task automatic t_range_high();
    do_reset(2'b10, 2'b00, 4'b1001, 4'b0001, 4'b0001, 4'b1001);
    repeat (40) tick("R5,R4");
  endtask

  // R6, R7: divide and invert
  task automatic t_divs();
    do_reset(2'b10, 2'b00, 4'b0101, 4'b0101, 4'b0000, 4'b0000);
    repeat (43) tick("R6,R7");
    b3_sel = 4'b1010; b4_sel = 4'b1010;
    repeat (48) tick("R6,R7");
  endtask

  // R8: code 11 is M everywhere
  task automatic t_illegal();
    do_reset(2'b11, 2'b00, 4'b1111, 4'b1100, 4'b0011, 4'b1110);
    repeat (48) tick("R8");
  endtask

  // R9: mid-period change waits for the boundary
  task automatic t_midchange();
    do_reset(2'b00, 2'b00, 4'b0101, 4'b0101, 4'b0101, 4'b0101);
    repeat (10) tick("R9");
    range_sel = 2'b10; b1_sel = 4'b1010; b3_sel = 4'b0001;
    repeat (40) tick("R9");
    range_sel = 2'b01; b2_sel = 4'b0000;
    repeat (5) tick("R9");
    b2_sel = 4'b1010;
    repeat (30) tick("R9");
  endtask

  // R10, R11: reference bypass with divide and invert
  task automatic t_bypass(input logic [1:0] ts);
    do_reset(2'b01, ts, 4'b1010, 4'b0000, 4'b0000, 4'b1010);
    for (int i = 0; i < 60; i++) begin
      ref_in = ((i / 3) % 2) == 1;
      tick("R10,R11");
    end
    b3_sel = 4'b1010;
    for (int i = 0; i < 60; i++) begin
      ref_in = ((i / 2) % 2) == 0;
      tick("R10,R11");
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    rst_n = 0; ref_in = 0; range_sel = 0; test_sel = 0;
    b1_sel = 4'b0101; b2_sel = 4'b0101; b3_sel = 4'b0101; b4_sel = 4'b0101;
    t_range_low();
    t_range_mid();
    t_range_high();
    t_divs();
    t_illegal();
    t_midchange();
    t_bypass(2'b01);
    t_bypass(2'b10);
    t_bypass(2'b11);
    done = 1;
    finish_run();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish got=hung exp=done");
      finish_run();
    end
  end

endmodule